// File: doc/BRIEF.md
# Word Address Generator for Loads and Stores

This block forms the effective word address of a load or store in a small load/store processor. On each cycle that `req_valid` is high it takes a 3-bit form selector, the base and index register values, a 16-bit displacement and a 32-bit address field from the instruction. It registers the resulting 32-bit address together with a valid strobe, so the result is ready one clock later, inside a single data-memory cycle.

There are five forms. Two take the 32-bit instruction field as the address. Two add a register value to either the sign-extended displacement or the index register. One shifts the base left by a small count. Each form uses at most one arithmetic step, and the two adding forms share one adder. Alongside the address the block reports three flags: an unused selector code or a bad shift count, a lost result (signed add overflow, or set bits shifted out), and an address that lies past the top of the word space.

Top module: `agu_addr_gen`

## Requirements
- R1: Selector 0 (long immediate) and selector 1 (absolute) both give the 32-bit instruction field `long_field` unchanged as the address. The lost-result flag stays low for both.
- R2: Selector 2 gives `base_val` plus `disp_field` sign-extended from bit 15, taken modulo 2^32.
- R3: Selector 3 gives `base_val` plus `index_val`, taken modulo 2^32.
- R4: `lost_flag` is set in two cases. For selectors 2 and 3 it is set when the add overflows as a signed 32-bit operation. For selector 4 it is set when any bit that is shifted out of bit 31 is a one. It is low for every other result.
- R5: Selector 4 gives `base_val` shifted left by `shamt`, and only counts 1 to 4 are accepted. A count of 0 or 5 to 7 is treated as illegal: `bad_flag` is high and the address is zero.
- R6: Selectors 5, 6 and 7 set `bad_flag` and give address zero, with `lost_flag` and `range_flag` low.
- R7: The address and flags of a request accepted on one rising edge appear at the outputs after that edge. `addr_valid` is high exactly in the cycle after each cycle in which `req_valid` was high, so back-to-back requests give back-to-back results.
- R8: `range_flag` is high when any address bit at or above bit 24 (the default word-space width) is set. It is low whenever `bad_flag` is high.
- R9: In a cycle with `req_valid` low, `addr_valid` falls on the next edge while the address and all flags keep their previous values, whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `addr_valid`, the address and all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Address form selector (0 to 4 legal) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp_field | input | 16 | Signed displacement from the instruction |
| long_field | input | 32 | 32-bit address field from the instruction |
| shamt | input | 3 | Shift count for the shifted-base form |
| addr_valid | output | 1 | Registered result strobe |
| addr | output | 32 | Registered effective address |
| bad_flag | output | 1 | Illegal selector or shift count |
| lost_flag | output | 1 | Signed add overflow or set bits shifted out |
| range_flag | output | 1 | Address lies outside the word space |

## Verification
The bench sweeps every selector code against every shift count, using operands placed at the signed limits, at all-ones and at the word-space edge. A design that zero-extends the displacement would give wrong addresses for negative offsets. One that checks unsigned carry would raise `lost_flag` on 0xFFFFFFFF+1 and miss overflow on 0x7FFFFFFF+1. A shifter that accepts counts of 0 or 5 and above would produce an address where zero and `bad_flag` are expected. The bench also drops `req_valid` while changing every other input, which catches a result register that reloads when it should hold.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned AW = 32;

    typedef enum logic [2:0] {
        FORM_LONG_IMM = 3'd0,
        FORM_ABSOLUTE = 3'd1,
        FORM_BASE_DSP = 3'd2,
        FORM_BASE_IDX = 3'd3,
        FORM_BASE_SHL = 3'd4
    } form_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          bad;
        logic          lost;
        logic          oor;
    } agu_res_t;

endpackage

// File: rtl/agu_adder.sv
module agu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         sovf
);
    always_comb begin
        sum  = opa + opb;
        // signed overflow: operands share a sign that the sum does not
        sovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
    end
endmodule

// File: rtl/agu_shifter.sv
module agu_shifter #(
    parameter int unsigned W       = 32,
    parameter int unsigned MAX_SH  = 4,
    parameter int unsigned SHAMT_W = 3
) (
    input  logic [W-1:0]       din,
    input  logic [SHAMT_W-1:0] cnt,
    output logic [W-1:0]       dout,
    output logic               lost,
    output logic               cnt_ok
);
    logic [W-1:0] stage [MAX_SH+1];
    logic         drop  [MAX_SH+1];

    assign stage[0] = din;
    assign drop[0]  = 1'b0;

    for (genvar k = 1; k <= MAX_SH; k++) begin : g_amt
        assign stage[k] = din << k;
        assign drop[k]  = |din[W-1 -: k];
    end

    always_comb begin
        dout   = '0;
        lost   = 1'b0;
        cnt_ok = (cnt >= SHAMT_W'(1)) && (cnt <= SHAMT_W'(MAX_SH));
        for (int k = 1; k <= MAX_SH; k++) begin
            if (cnt == SHAMT_W'(k)) begin
                dout = stage[k];
                lost = drop[k];
            end
        end
    end
endmodule

// File: rtl/agu_range.sv
module agu_range #(
    parameter int unsigned W          = 32,
    parameter int unsigned SPACE_BITS = 24
) (
    input  logic [W-1:0] addr_in,
    output logic         outside
);
    localparam int unsigned HI_W = W - SPACE_BITS;

    if (HI_W == 0) begin : g_full
        assign outside = 1'b0;
    end else begin : g_part
        assign outside = |addr_in[W-1 -: HI_W];
    end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int unsigned DISP_W     = 16,
    parameter int unsigned MAX_SHIFT  = 4,
    parameter int unsigned SHAMT_W    = 3,
    parameter int unsigned SPACE_BITS = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         mode,
    input  logic [31:0]        base_val,
    input  logic [31:0]        index_val,
    input  logic [DISP_W-1:0]  disp_field,
    input  logic [31:0]        long_field,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               addr_valid,
    output logic [31:0]        addr,
    output logic               bad_flag,
    output logic               lost_flag,
    output logic               range_flag
);
    localparam int unsigned EXT_W = AW - DISP_W;

    agu_res_t res_d, res_q;
    logic     past_ok_d, past_ok_q;

    // shared adder operand select
    logic [AW-1:0] disp_ext, add_b, add_sum, shl_out, sel_addr;
    logic          add_ovf, shl_lost, shl_ok, sel_bad, sel_lost, sel_oor;

    assign disp_ext = {{EXT_W{disp_field[DISP_W-1]}}, disp_field};
    assign add_b    = (mode == FORM_BASE_IDX) ? index_val : disp_ext;

    agu_adder #(.W(AW)) u_add (
        .opa  (base_val),
        .opb  (add_b),
        .sum  (add_sum),
        .sovf (add_ovf)
    );

    agu_shifter #(.W(AW), .MAX_SH(MAX_SHIFT), .SHAMT_W(SHAMT_W)) u_shl (
        .din    (base_val),
        .cnt    (shamt),
        .dout   (shl_out),
        .lost   (shl_lost),
        .cnt_ok (shl_ok)
    );

    always_comb begin
        sel_addr = '0;
        sel_bad  = 1'b0;
        sel_lost = 1'b0;
        case (mode)
            FORM_LONG_IMM,
            FORM_ABSOLUTE: sel_addr = long_field;
            FORM_BASE_DSP,
            FORM_BASE_IDX: begin
                sel_addr = add_sum;
                sel_lost = add_ovf;
            end
            FORM_BASE_SHL: begin
                if (shl_ok) begin
                    sel_addr = shl_out;
                    sel_lost = shl_lost;
                end else begin
                    sel_bad = 1'b1;
                end
            end
            default: sel_bad = 1'b1;
        endcase
    end

    agu_range #(.W(AW), .SPACE_BITS(SPACE_BITS)) u_rng (
        .addr_in (sel_addr),
        .outside (sel_oor)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        past_ok_d = 1'b1;
        if (req_valid) begin
            res_d.addr = sel_addr;
            res_d.bad  = sel_bad;
            res_d.lost = sel_lost;
            res_d.oor  = sel_oor && !sel_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            past_ok_q <= 1'b0;
        end else begin
            res_q     <= res_d;
            past_ok_q <= past_ok_d;
        end
    end

    assign addr_valid = res_q.vld;
    assign addr       = res_q.addr;
    assign bad_flag   = res_q.bad;
    assign lost_flag  = res_q.lost;
    assign range_flag = res_q.oor;

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_valid);
    a_r6_bad_gives_zero: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && bad_flag) |-> (addr == '0 && !lost_flag));
    a_r8_bad_not_outside: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && bad_flag) |-> !range_flag);
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$past(req_valid)) |-> ($stable(addr) && $stable(lost_flag)));
    a_r4_lost_only_arith: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && addr_valid && lost_flag) |->
            ($past(mode) == 3'd2 || $past(mode) == 3'd3 || $past(mode) == 3'd4));
    a_r2_disp_sum: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd2) |=>
            (addr == $past(base_val) + {{EXT_W{$past(disp_field[DISP_W-1])}}, $past(disp_field)}));

endmodule

// File: tb/sim_agu_addr_gen.sv
`timescale 1ns/1ps
module sim_agu_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  mode;
    logic [31:0] base_val, index_val, long_field;
    logic [15:0] disp_field;
    logic [2:0]  shamt;
    logic        addr_valid, bad_flag, lost_flag, range_flag;
    logic [31:0] addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    agu_addr_gen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .base_val(base_val), .index_val(index_val), .disp_field(disp_field),
        .long_field(long_field), .shamt(shamt), .addr_valid(addr_valid),
        .addr(addr), .bad_flag(bad_flag), .lost_flag(lost_flag),
        .range_flag(range_flag)
    );

    function automatic logic [31:0] pick_base(int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;  3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;  5: return 32'h00FF_FFFF;
            6: return 32'h1234_5678;  7: return 32'h0F00_0000;
            8: return 32'hC000_0001;  9: return 32'h1000_0000;
            10: return 32'h0080_0000; default: return 32'h4000_0000;
        endcase
    endfunction

    function automatic logic [31:0] pick_idx(int j);
        case (j)
            0: return 32'h0000_0000; 1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF; 3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000; default: return 32'h0001_0000;
        endcase
    endfunction

    function automatic logic [15:0] pick_disp(int j);
        case (j)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF;
            3: return 16'h7FFF; 4: return 16'h8000; default: return 16'h1234;
        endcase
    endfunction

    task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // arithmetic model derived from the requirements
    task automatic model(input logic [2:0] m, input logic [31:0] b, input logic [31:0] ix,
                         input logic [15:0] d, input logic [31:0] lf, input logic [2:0] n,
                         output logic [31:0] ea, output logic bad, output logic lost,
                         output logic oor);
        longint s;
        logic [63:0] wide;
        ea = 0; bad = 0; lost = 0;
        case (m)
            3'd0, 3'd1: ea = lf;
            3'd2: begin
                s = longint'($signed(b)) + longint'($signed(d));
                ea = 32'(s);
                lost = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            3'd3: begin
                s = longint'($signed(b)) + longint'($signed(ix));
                ea = 32'(s);
                lost = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            3'd4: begin
                if (n >= 3'd1 && n <= 3'd4) begin
                    wide = {32'h0, b} << n;
                    ea = wide[31:0];
                    lost = (wide[63:32] != 0);
                end else bad = 1;
            end
            default: bad = 1;
        endcase
        oor = !bad && (ea >= 32'h0100_0000);
    endtask

    task automatic tag_for(input logic [2:0] m, input logic [2:0] n, output string t);
        case (m)
            3'd0, 3'd1: t = "R1";
            3'd2: t = "R2";
            3'd3: t = "R3";
            3'd4: t = (n >= 1 && n <= 4) ? "R5" : "R5-badcnt";
            default: t = "R6";
        endcase
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ea, last_addr;
        logic bad, lost, oor, last_lost, last_bad, last_oor;
        string tg;
        rst = 1; req_valid = 0; mode = 0; base_val = 0; index_val = 0;
        disp_field = 0; long_field = 0; shamt = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check1("R10", "valid", 32'(addr_valid), 0);
        check1("R10", "addr", addr, 0);
        check1("R10", "flags", {29'h0, bad_flag, lost_flag, range_flag}, 0);
        rst = 0;
        @(negedge clk);
        check1("R7", "idle valid", 32'(addr_valid), 0);

        // full sweep, back-to-back requests
        for (int m = 0; m < 8; m++) begin
            for (int n = 0; n < 8; n++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        req_valid  = 1;
                        mode       = 3'(m);
                        shamt      = 3'(n);
                        base_val   = pick_base(i);
                        index_val  = pick_idx(j);
                        disp_field = pick_disp(j);
                        long_field = pick_base(i) ^ 32'h5A5A_0000;
                        model(mode, base_val, index_val, disp_field, long_field, shamt,
                              ea, bad, lost, oor);
                        tag_for(mode, shamt, tg);
                        @(negedge clk);
                        check1("R7", "valid", 32'(addr_valid), 1);
                        check1(tg, "addr", addr, ea);
                        check1((m > 4 || (m == 4 && (n == 0 || n > 4))) ? "R6" : "R5",
                               "bad", 32'(bad_flag), 32'(bad));
                        check1("R4", "lost", 32'(lost_flag), 32'(lost));
                        check1("R8", "range", 32'(range_flag), 32'(oor));
                    end
                end
            end
        end

        // R9: idle cycles hold results while inputs move
        last_addr = addr; last_bad = bad_flag; last_lost = lost_flag; last_oor = range_flag;
        for (int k = 0; k < 4; k++) begin
            req_valid = 0;
            mode = 3'(k + 2);
            base_val = 32'hDEAD_0000 + 32'(k);
            index_val = 32'h8000_0000;
            shamt = 3'd2;
            @(negedge clk);
            check1("R9", "valid low", 32'(addr_valid), 0);
            check1("R9", "addr held", addr, last_addr);
            check1("R9", "flags held", {29'h0, bad_flag, lost_flag, range_flag},
                   {29'h0, last_bad, last_lost, last_oor});
        end

        // R7: a single request after idle shows up after one edge only
        req_valid = 1; mode = 3'd3; base_val = 32'h0000_0010; index_val = 32'h0000_0005;
        @(negedge clk);
        req_valid = 0;
        check1("R7", "single valid", 32'(addr_valid), 1);
        check1("R3", "single addr", addr, 32'h0000_0015);
        @(negedge clk);
        check1("R7", "single drop", 32'(addr_valid), 0);

        // R10: reset mid-stream clears outputs
        req_valid = 1; mode = 3'd0; long_field = 32'hFFFF_FFFF;
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        check1("R10", "valid after rst", 32'(addr_valid), 0);
        check1("R10", "addr after rst", addr, 0);
        check1("R10", "flags after rst", {29'h0, bad_flag, lost_flag, range_flag}, 0);
        rst = 0; req_valid = 0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule